// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block generates the instruction fetch address for a small controller with 12-bit instructions. It keeps an 11-bit program counter and a return stack of two levels. On every clock edge it carries out one control operation given on `op_i`: a step to the next address, a jump, a subroutine call, a return, or a write of a computed 8-bit value into the counter.

The address space is split into pages of 512 words. Jumps, calls and computed writes never take their page from the current counter. They take it from the two pre-select bits on `page_sel_i`, which come from an outside status register. A plain step from the last word of a page carries into the next page and leaves the pre-select bits alone. The next jump then lands back in the page that is pre-selected. Calls and computed writes force address bit 8 to zero, so their targets always fall in the lower half of a page.

A parameter `SINGLE_PAGE` selects a 512-word variant. In that variant the page bits are ignored and the upper address bits stay at zero.

Top module: `prog_counter_paged`

## Requirements
- R1: While `rst_n` is low the fetch address is all ones (7FFh, or 1FFh in the single-page variant) and both stack levels read zero.
- R2: The increment operation adds one to the address. The carry crosses page boundaries (1FFh goes to 200h) and 7FFh wraps to 000h.
- R3: A jump loads address bits [8:0] from `imm_i` and bits [10:9] from `page_sel_i`.
- R4: A call pushes the current address plus one onto the stack. It then loads bits [7:0] from `imm_i[7:0]`, clears bit 8 and loads bits [10:9] from `page_sel_i`.
- R5: A return loads the address from the top level. The bottom level moves into the top level and also keeps its own value. A return from an empty stack yields the stale contents and raises no fault.
- R6: A computed write loads bits [7:0] from `alu_i`, clears bit 8 and loads bits [10:9] from `page_sel_i`.
- R7: After an increment carries into another page, a jump goes to the page on `page_sel_i` and not to the page of the current address.
- R8: A push moves the top level into the bottom level, and the old bottom value is lost. A third push without a pop therefore discards the oldest return address.
- R9: With `SINGLE_PAGE` set, address bits [10:9] and the upper bits of both stack levels are always zero, `page_sel_i` has no effect, and 1FFh increments to 000h.
- R10: The operation codes on `op_i` are 0 for increment, 1 for jump, 2 for call, 3 for return and 4 for computed write. Codes 5, 6 and 7 act as increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Control operation code for this cycle |
| page_sel_i | input | 2 | Page pre-select bits from the status register |
| imm_i | input | 9 | Jump target (all 9 bits) or call target (low 8 bits) |
| alu_i | input | 8 | Computed value for a write to the counter |
| fetch_addr_o | output | 11 | Current fetch address |
| stack_top_o | output | 11 | Top return stack level |
| stack_bot_o | output | 11 | Bottom return stack level |

## Verification
A paged and a single-page instance run side by side from the same inputs. Each is compared cycle by cycle against an arithmetic model.

A jump sweep over every page and every 9-bit immediate separates the page input from the immediate bits. A computed-write sweep over all 8-bit values and pages shows that bit 8 is cleared. Directed sequences cover the 1FFh carry into page 1 followed by a jump back to page 0, three nested calls that overflow the stack, and returns on an empty stack. A long pseudo-random mix of all eight codes exercises interleaved pushes and pops, including the unused codes.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_WRITE = 3'd4
    } pc_op_e;

endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 2,
    parameter bit SINGLE_PAGE = 1'b0,
    localparam int LOW_W      = ADDR_W - PAGE_W
) (
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] pc_q_i,
    input  logic [PAGE_W-1:0] page_sel_i,
    input  logic [LOW_W-1:0]  imm_i,
    input  logic [LOW_W-2:0]  alu_i,
    input  logic [ADDR_W-1:0] stack_top_i,
    output logic [ADDR_W-1:0] pc_d_o,
    output logic [ADDR_W-1:0] link_o,
    output logic              push_o,
    output logic              pop_o
);

    logic [PAGE_W-1:0] page_eff;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] raw_next;

    // Variant choice: the page source and the width of the live address
    if (SINGLE_PAGE) begin : g_one_page
        assign page_eff = '0;
        assign pc_d_o   = {{PAGE_W{1'b0}}, raw_next[LOW_W-1:0]};
        assign link_o   = {{PAGE_W{1'b0}}, seq_addr[LOW_W-1:0]};
    end else begin : g_paged
        assign page_eff = page_sel_i;
        assign pc_d_o   = raw_next;
        assign link_o   = seq_addr;
    end

    assign seq_addr = pc_q_i + ADDR_W'(1);

    always_comb begin
        raw_next = seq_addr;
        push_o   = 1'b0;
        pop_o    = 1'b0;
        unique case (pc_op_e'(op_i))
            OP_JUMP: raw_next = {page_eff, imm_i};
            OP_CALL: begin
                raw_next = {page_eff, 1'b0, imm_i[LOW_W-2:0]};
                push_o   = 1'b1;
            end
            OP_RET: begin
                raw_next = stack_top_i;
                pop_o    = 1'b1;
            end
            OP_WRITE: raw_next = {page_eff, 1'b0, alu_i};
            default:  raw_next = seq_addr;
        endcase
    end

endmodule

// File: rtl/ret_stack_shift.sv
module ret_stack_shift #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 2
) (
    input  logic                        push_i,
    input  logic                        pop_i,
    input  logic [WIDTH-1:0]            link_i,
    input  logic [DEPTH-1:0][WIDTH-1:0] lvl_q_i,
    output logic [DEPTH-1:0][WIDTH-1:0] lvl_d_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [WIDTH-1:0] from_above;
        logic [WIDTH-1:0] from_below;

        if (g == 0) begin : g_head
            assign from_above = link_i;
        end else begin : g_body
            assign from_above = lvl_q_i[g-1];
        end

        // The deepest level keeps its value when the stack is popped
        if (g == DEPTH - 1) begin : g_tail
            assign from_below = lvl_q_i[g];
        end else begin : g_inner
            assign from_below = lvl_q_i[g+1];
        end

        assign lvl_d_o[g] = push_i ? from_above :
                            pop_i  ? from_below : lvl_q_i[g];
    end

endmodule

// File: rtl/prog_counter_paged.sv
module prog_counter_paged #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 2,
    parameter int STK_DEPTH   = 2,
    parameter bit SINGLE_PAGE = 1'b0,
    localparam int LOW_W      = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PAGE_W-1:0] page_sel_i,
    input  logic [LOW_W-1:0]  imm_i,
    input  logic [LOW_W-2:0]  alu_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] stack_top_o,
    output logic [ADDR_W-1:0] stack_bot_o
);

    localparam logic [ADDR_W-1:0] RESET_PC = SINGLE_PAGE ?
        {{PAGE_W{1'b0}}, {LOW_W{1'b1}}} : {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0]                  pc;
        logic [STK_DEPTH-1:0][ADDR_W-1:0]   stk;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0]                pc_next;
    logic [ADDR_W-1:0]                link;
    logic                             push;
    logic                             pop;
    logic [STK_DEPTH-1:0][ADDR_W-1:0] stk_next;

    pc_next_calc #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .SINGLE_PAGE (SINGLE_PAGE)
    ) i_next (
        .op_i        (op_i),
        .pc_q_i      (state_q.pc),
        .page_sel_i  (page_sel_i),
        .imm_i       (imm_i),
        .alu_i       (alu_i),
        .stack_top_i (state_q.stk[0]),
        .pc_d_o      (pc_next),
        .link_o      (link),
        .push_o      (push),
        .pop_o       (pop)
    );

    ret_stack_shift #(
        .WIDTH (ADDR_W),
        .DEPTH (STK_DEPTH)
    ) i_stack (
        .push_i  (push),
        .pop_i   (pop),
        .link_i  (link),
        .lvl_q_i (state_q.stk),
        .lvl_d_o (stk_next)
    );

    always_comb begin
        state_d     = state_q;
        state_d.pc  = pc_next;
        state_d.stk = stk_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc  <= RESET_PC;
            state_q.stk <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_addr_o = state_q.pc;
    assign stack_top_o  = state_q.stk[0];
    assign stack_bot_o  = state_q.stk[STK_DEPTH-1];

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 2,
    parameter bit SINGLE_PAGE = 1'b0,
    localparam int LOW_W      = ADDR_W - PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [PAGE_W-1:0] page_sel_i,
    input logic [LOW_W-1:0]  imm_i,
    input logic [LOW_W-2:0]  alu_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [ADDR_W-1:0] stack_top_o,
    input logic [ADDR_W-1:0] stack_bot_o
);

    localparam logic [ADDR_W-1:0] MASK = SINGLE_PAGE ?
        {{PAGE_W{1'b0}}, {LOW_W{1'b1}}} : {ADDR_W{1'b1}};

    p_reset_ones_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr_o == MASK && stack_top_o == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0) |=> fetch_addr_o == ((ADDR_W'($past(fetch_addr_o)) + ADDR_W'(1)) & MASK));

    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> fetch_addr_o == ({$past(page_sel_i), $past(imm_i)} & MASK));

    p_call_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> (stack_top_o == ((ADDR_W'($past(fetch_addr_o)) + ADDR_W'(1)) & MASK)
                            && fetch_addr_o[LOW_W-1] == 1'b0));

    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (fetch_addr_o == $past(stack_top_o)
                            && stack_top_o == $past(stack_bot_o) && $stable(stack_bot_o)));

    p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> fetch_addr_o == ({$past(page_sel_i), 1'b0, $past(alu_i)} & MASK));

    p_push_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> stack_bot_o == $past(stack_top_o));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        SINGLE_PAGE |-> ((fetch_addr_o & ~MASK) == '0 && (stack_top_o & ~MASK) == '0
                         && (stack_bot_o & ~MASK) == '0));

endmodule

bind prog_counter_paged pc_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .SINGLE_PAGE (SINGLE_PAGE)
) i_pc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .page_sel_i   (page_sel_i),
    .imm_i        (imm_i),
    .alu_i        (alu_i),
    .fetch_addr_o (fetch_addr_o),
    .stack_top_o  (stack_top_o),
    .stack_bot_o  (stack_bot_o)
);

// File: tb/test_prog_counter_paged.sv
module test_prog_counter_paged;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  pg = 2'd0;
    logic [8:0]  im = 9'd0;
    logic [7:0]  al = 8'd0;
    logic [10:0] fa_m, st_m, sb_m, fa_s, st_s, sb_s;

    int n_chk = 0;
    int n_fail = 0;

    logic [10:0] m_pc [2];
    logic [10:0] m_s0 [2];
    logic [10:0] m_s1 [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_counter_paged i_prog_counter_paged (
        .clk(clk), .rst_n(rst_n), .op_i(op), .page_sel_i(pg), .imm_i(im), .alu_i(al),
        .fetch_addr_o(fa_m), .stack_top_o(st_m), .stack_bot_o(sb_m)
    );

    prog_counter_paged #(.SINGLE_PAGE(1'b1)) i_prog_counter_paged_sp (
        .clk(clk), .rst_n(rst_n), .op_i(op), .page_sel_i(pg), .imm_i(im), .alu_i(al),
        .fetch_addr_o(fa_s), .stack_top_o(st_s), .stack_bot_o(sb_s)
    );

    function automatic logic [10:0] mask_of(input int v);
        return (v == 1) ? 11'h1FF : 11'h7FF;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd1: return "R3 jump";
            3'd2: return "R4 R8 call";
            3'd3: return "R5 return";
            3'd4: return "R6 write";
            3'd0: return "R2 step";
            default: return "R10 unused code";
        endcase
    endfunction

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_pc[v] = mask_of(v);
            m_s0[v] = '0;
            m_s1[v] = '0;
        end
    endtask

    task automatic model_step();
        for (int v = 0; v < 2; v++) begin
            logic [10:0] m, inc;
            m   = mask_of(v);
            inc = (m_pc[v] + 11'd1) & m;
            case (op)
                3'd1: m_pc[v] = {pg, im} & m;
                3'd2: begin
                    m_s1[v] = m_s0[v];
                    m_s0[v] = inc;
                    m_pc[v] = {pg, 1'b0, im[7:0]} & m;
                end
                3'd3: begin
                    m_pc[v] = m_s0[v];
                    m_s0[v] = m_s1[v];
                end
                3'd4: m_pc[v] = {pg, 1'b0, al} & m;
                default: m_pc[v] = inc;
            endcase
        end
    endtask

    task automatic compare(input string tag);
        for (int v = 0; v < 2; v++) begin
            logic [32:0] got, exp;
            got = (v == 1) ? {fa_s, st_s, sb_s} : {fa_m, st_m, sb_m};
            exp = {m_pc[v], m_s0[v], m_s1[v]};
            n_chk++;
            if (got !== exp) begin
                n_fail++;
                $display("FAIL %s (variant %0d): pc/top/bot got %h %h %h expected %h %h %h",
                         tag, v, got[32:22], got[21:11], got[10:0],
                         exp[32:22], exp[21:11], exp[10:0]);
            end
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic apply(input logic [2:0] o, input logic [1:0] p, input logic [8:0] i,
                         input logic [7:0] a, input string tag);
        op = o; pg = p; im = i; al = a;
        @(negedge clk);
        model_step();
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;

        apply(3'd0, 2'd2, 9'h000, 8'h00, "R2 R9 wrap from reset address");
        apply(3'd1, 2'd0, 9'h1FF, 8'h00, "R3 jump to page end");
        apply(3'd0, 2'd1, 9'h000, 8'h00, "R2 R9 carry into next page");
        apply(3'd1, 2'd0, 9'h005, 8'h00, "R7 jump returns to preselected page");
        apply(3'd1, 2'd3, 9'h0AB, 8'h00, "R3 R9 jump with page 3");
        apply(3'd2, 2'd1, 9'h1FF, 8'h00, "R4 call clears bit 8");
        apply(3'd2, 2'd2, 9'h010, 8'h00, "R4 nested call");
        apply(3'd2, 2'd0, 9'h020, 8'h00, "R8 third push drops oldest");
        apply(3'd3, 2'd3, 9'h1FF, 8'hFF, "R5 first return");
        apply(3'd3, 2'd3, 9'h1FF, 8'hFF, "R5 second return");
        apply(3'd3, 2'd3, 9'h1FF, 8'hFF, "R5 return on empty stack");
        apply(3'd4, 2'd3, 9'h1FF, 8'hFF, "R6 computed write");
        apply(3'd5, 2'd1, 9'h123, 8'h45, "R10 code 5 steps");
        apply(3'd6, 2'd2, 9'h123, 8'h45, "R10 code 6 steps");
        apply(3'd7, 2'd3, 9'h123, 8'h45, "R10 code 7 steps");

        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 512; i++) begin
                apply(3'd1, 2'(p), 9'(i), 8'h00, "R3 R9 jump sweep");
            end
            for (int a = 0; a < 256; a++) begin
                apply(3'd4, 2'(p), 9'h1FF, 8'(a), "R6 R9 write sweep");
            end
        end

        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply(lf[2:0], lf[4:3], lf[13:5], lf[15:8], tag_of(lf[2:0]));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule